// File: doc/BRIEF.md
# PHY Management Command Controller

This block runs one clause-22 PHY management transaction on a two-wire serial management bus. Software controls it through a single 32-bit command word. A write to that word, when the block is idle, stores the word. If the top bit of the word is set, the write also launches a frame on the management clock and data lines. The same word then serves as the status: the top bit stays high while the frame is on the wire, and software polls it until it drops.

A frame has 64 bit times. Each bit time is one period of a management clock divided down from the system clock. A read frame releases the data line from the turnaround onward. It shifts in the sixteen bits returned by the PHY, and they replace the low half of the command word. A write frame drives every bit, including the turnaround and the sixteen data bits.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command word reads 0, the management clock is low and the data output enable is low.
- R2: A write with bit 31 = 1 while bit 31 reads 0 starts a frame. Bit 31 reads 1 until the clock edge 128*CLK_HALF system cycles after the write edge, and reads 0 from that edge on.
- R3: A write frame (bit 30 = 0) carries, MSB first, 32 ones, then 01, then 01, then bits 25:21, then bits 20:16, then 10, then bits 15:0. The output enable stays high for all 64 bit times.
- R4: A read frame (bit 30 = 1) carries 32 ones, then 01, then 10, then the two 5-bit address fields. The output enable is low for the last 18 bit times (the turnaround and the data).
- R5: On a read, the data input is sampled on the rising management clock edges of the last 16 bit times, MSB first. When bit 31 clears, bits 15:0 hold the sampled value and bits 30:16 keep their written value.
- R6: A write to the command word while bit 31 reads 1 has no effect on the word or on the frame in progress.
- R7: A write with bit 31 = 0 while idle stores the word and produces no management clock edges.
- R8: The management clock is low while idle. It has a period of 2*CLK_HALF system cycles, high for CLK_HALF of them. The data output changes only while the clock is low.
- R9: After a write frame, the word reads back as written with bit 31 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for management data |
| mdio_i | input | 1 | Management data in |

## Verification
The checks on output stability and the idle clock level depend only on the block's own state. The read-capture check depends on the PHY side: the data input must settle before each rising management clock edge. The bench's PHY model changes the data input only on falling management clock edges, and it drives a fixed response word for each read. Software-side stimulus always waits out the full frame length before issuing a new command, except for the one deliberate write issued while busy.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int CLK_HALF = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int              CW        = $clog2(CLK_HALF + 1);
  localparam logic [CW-1:0]   CNT_LAST  = CW'(CLK_HALF - 1);
  localparam logic [5:0]      BIT_HDR   = 6'd32;
  localparam logic [5:0]      BIT_TA    = 6'd46;
  localparam logic [5:0]      BIT_DATA  = 6'd48;
  localparam logic [5:0]      BIT_LAST  = 6'd63;

  logic [31:0]   cmd;
  logic [5:0]    idx;
  logic [CW-1:0] cnt;
  logic [31:0]   sh;
  logic [15:0]   rd;
  logic          mdc_q;

  wire busy  = cmd[31];
  wire is_rd = cmd[30];
  wire tick  = busy && (cnt == CNT_LAST);

  wire w_rd = reg_wdata[30];
  wire [31:0] hdr = {2'b01,
                     w_rd ? 2'b10 : 2'b01,
                     reg_wdata[25:21],
                     reg_wdata[20:16],
                     w_rd ? 2'b00 : 2'b10,
                     w_rd ? 16'h0000 : reg_wdata[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      idx   <= '0;
      cnt   <= '0;
      sh    <= '0;
      rd    <= '0;
      mdc_q <= 1'b0;
    end else if (!busy) begin
      if (reg_wr) begin
        cmd   <= reg_wdata;
        idx   <= '0;
        cnt   <= '0;
        mdc_q <= 1'b0;
        sh    <= hdr;
      end
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (is_rd && idx >= BIT_DATA)
            rd <= {rd[14:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          if (idx == BIT_LAST) begin
            cmd[31] <= 1'b0;
            if (is_rd)
              cmd[15:0] <= rd;
          end else begin
            idx <= idx + 1'b1;
            if (idx >= BIT_HDR)
              sh <= {sh[30:0], 1'b0};
          end
        end
      end
    end
  end

  assign reg_rdata = cmd;
  assign mdc       = mdc_q;
  assign mdio_oe   = busy && (!is_rd || idx < BIT_TA);
  assign mdio_o    = mdio_oe && ((idx < BIT_HDR) || sh[31]);

endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[31] |-> (!mdc && !mdio_oe));

  // R8
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R6
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31] && $past(reg_rdata[31])) |-> $stable(reg_rdata[30:0]));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31] && reg_rdata[30] && $past(reg_rdata[31])) |-> !$rose(mdio_oe));

  // R2
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[31]) |-> $fell(mdc));

endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_cmd_ctrl.sv
module sim_mdio_cmd_ctrl;
  localparam int H    = 2;
  localparam int TLEN = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;

  always #4 clk = ~clk;

  mdio_cmd_ctrl #(.CLK_HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int nchk = 0;
  int nbad = 0;
  int nrise = 0;
  int hicnt = 0;
  logic [63:0] cap = '0;
  logic [63:0] oem = '0;
  logic [15:0] cur_resp = '0;

  always @(posedge mdc) begin
    cap   <= {cap[62:0], mdio_o};
    oem   <= {oem[62:0], mdio_oe};
    nrise <= nrise + 1;
  end

  always @(negedge mdc) begin
    int n;
    n = nrise % 64;
    mdio_i <= (n >= 48) ? cur_resp[63 - n] : 1'b1;
  end

  always @(posedge clk) if (mdc) hicnt <= hicnt + 1;

  // {command word, PHY response}
  localparam logic [47:0] VEC [6] = '{
    {32'h8020_1234, 16'h0000},
    {32'hC3FF_0000, 16'hA5C3},
    {32'h83FF_FFFF, 16'h0000},
    {32'hC000_0000, 16'h0001},
    {32'h8155_0000, 16'h0000},
    {32'hC2AA_00FF, 16'h8000}
  };

  localparam logic [63:0] RD_MASK = {{46{1'b1}}, 18'h0};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    exp_frame = {32'hFFFF_FFFF, 2'b01, w[30] ? 2'b10 : 2'b01, w[25:21], w[20:16],
                 w[30] ? 2'b00 : 2'b10, w[30] ? 16'h0000 : w[15:0]};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 word", 64'(reg_rdata), 64'h0);
    check("R1 mdc", 64'(mdc), 64'h0);
    check("R1 oe", 64'(mdio_oe), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] w;
      logic [63:0] ef;
      w = VEC[i][47:16];
      cur_resp = VEC[i][15:0];
      issue(w);
      repeat (TLEN) @(negedge clk);
      ef = exp_frame(w);
      if (w[30]) begin
        check("R4 read frame", cap & RD_MASK, ef & RD_MASK);
        check("R4 read oe", oem, RD_MASK);
        check("R5 read word", 64'(reg_rdata), 64'({1'b0, w[30:16], VEC[i][15:0]}));
      end else begin
        check("R3 write frame", cap, ef);
        check("R3 write oe", oem, {64{1'b1}});
        check("R9 write word", 64'(reg_rdata), 64'({1'b0, w[30:0]}));
      end
      repeat (3) @(negedge clk);
    end

    begin
      int r0;
      r0 = nrise;
      issue(32'h4123_4567);
      check("R7 stored", 64'(reg_rdata), 64'h4123_4567);
      repeat (20) @(negedge clk);
      check("R7 no clock", 64'(nrise - r0), 64'h0);
      check("R7 mdc low", 64'(mdc), 64'h0);
    end

    begin
      int r0, h0;
      r0 = nrise;
      h0 = hicnt;
      cur_resp = 16'h0000;
      issue(32'h8020_0055);
      repeat (TLEN - 1) @(negedge clk);
      check("R2 busy before end", 64'(reg_rdata[31]), 64'h1);
      @(negedge clk);
      check("R2 clear at end", 64'(reg_rdata[31]), 64'h0);
      check("R8 clock periods", 64'(nrise - r0), 64'd64);
      check("R8 high cycles", 64'(hicnt - h0), 64'(64 * H));
      check("R8 idle mdc", 64'(mdc), 64'h0);
    end

    repeat (3) @(negedge clk);
    cur_resp = 16'h3C3C;
    issue(32'hC0A3_0000);
    repeat (50) @(negedge clk);
    issue(32'h8000_FFFF);
    check("R6 word kept", 64'(reg_rdata), 64'hC0A3_0000);
    repeat (TLEN - 52) @(negedge clk);
    check("R6 frame kept", cap & RD_MASK, exp_frame(32'hC0A3_0000) & RD_MASK);
    check("R6 result", 64'(reg_rdata), 64'h40A3_3C3C);

    summary();
  end
endmodule